// File: doc/BRIEF.md
# Deserializer Word-Alignment Slip Controller

This block sits behind a 1:10 deserializer. It runs on the divided word clock and compares each received 10-bit parallel word with a programmable training pattern. While the words do not match, it asks the clock-alignment logic to slip the word boundary by one bit. Each request is a fixed pulse, followed by an enforced quiet period and a re-arm step. Because of this spacing, no request can move the boundary by more than one bit, and a new request is never raised on a stale comparison.

After the pattern has been seen on a set number of consecutive words, the block raises a locked flag. A mismatch while locked drops the flag and starts the search again. A wrapping counter reports how many slips have been requested since reset.

The slip request leaves the block through its own word-clock register. The request path therefore starts from a flop, with no combinational logic between the state machine and the pin.

Top module: `slip_align_ctrl`

## Requirements
- R1: `slipReq` is driven from a register. It rises exactly one word-clock cycle after the cycle in which `slipCount` advanced for that request.
- R2: Every slip request holds `slipReq` high for exactly two consecutive word-clock cycles.
- R3: Between two slip requests, `slipReq` stays low for at least three word-clock cycles.
- R4: A new request is raised only when the comparison of a word received after the previous request's quiet period reports a mismatch. Once the word matches, no further request is issued.
- R5: `slipCount` (4 bits) advances by one for each request and wraps from 9 to 0.
- R6: `locked` rises only after the pattern has matched on 4 (parameter) consecutive words. With an aligned word, enable high and reset released, `locked` is low after the fourth clock edge and high after the fifth.
- R7: A mismatch while locked leaves `locked` high for one more edge, clears it on the second edge, and resumes slipping.
- R8: While `enable` is low, no request is issued and `locked` is low. Dropping `enable` while locked clears `locked` on the next edge.
- R9: The synchronous active-high reset `rst` drives `slipReq` low, clears `locked` and `slipCount`, and returns the block to idle, even in the middle of a pulse.
- R10: With a deserializer that rotates the word left by one bit (`{w[8:0],w[9]}`) per request, any starting rotation of a pattern without rotational symmetry reaches lock after exactly that many requests, always fewer than ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word (divided) clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows comparison and slipping |
| rxWord | input | 10 | Parallel word from the deserializer |
| trainPattern | input | 10 | Expected training word |
| slipReq | output | 1 | Registered one-bit slip request to the alignment logic |
| locked | output | 1 | Pattern found on enough consecutive words |
| slipCount | output | 4 | Requests issued since reset, modulo 10 |

## Verification
The assertions assume that `rxWord` and `trainPattern` change only between word-clock edges and hold steady for the whole cycle. They also assume that the downstream alignment logic answers each request with at most one boundary shift, which the bench model does on the first high cycle of each pulse. `trainPattern` is held constant for each alignment run and changes only while reset is asserted. The patterns used have no rotational symmetry, so the number of slips needed is exactly the starting rotation.

// File: rtl/slip_pkg.sv
package slip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_PULSE_HI,
    ST_GAP_LO,
    ST_WAIT_REARM,
    ST_LOCKED
  } slipState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic syncRaw;   // unregistered slip request
    logic clrMiss;   // hold comparator miss indication low
    logic incSlip;   // advance slip counter
    logic incMatch;  // count one more matching word
    logic clrMatch;  // restart match run
    logic setLock;
    logic clrLock;
  } slipStrobe_t;

endpackage

// File: rtl/slip_datapath.sv
module slip_datapath
  import slip_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int LOCK_COUNT = 4,
  parameter int SLIP_MOD   = 10,
  parameter int SLIP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] trainPattern,
  input  slipStrobe_t       strobe,
  output logic              hitQ,
  output logic              missQ,
  output logic              matchDone,
  output logic              syncQ,
  output logic              lockedQ,
  output logic [SLIP_W-1:0] slipCnt
);

  localparam int MATCH_W = (LOCK_COUNT > 1) ? $clog2(LOCK_COUNT) : 1;
  localparam logic [MATCH_W-1:0] MATCH_LAST = MATCH_W'(LOCK_COUNT - 1);
  localparam logic [SLIP_W-1:0]  SLIP_LAST  = SLIP_W'(SLIP_MOD - 1);

  logic [WORD_W-1:0]  bitDiff;
  logic               wordEq;
  logic [MATCH_W-1:0] matchCnt;

  // Per-bit comparator
  for (genvar b = 0; b < WORD_W; b++) begin : g_cmp
    assign bitDiff[b] = rxWord[b] ^ trainPattern[b];
  end
  assign wordEq    = ~|bitDiff;
  assign matchDone = (matchCnt == MATCH_LAST);

  // Registered compare result; the miss indication can be forced low
  always_ff @(posedge clk) begin
    if (rst) begin
      hitQ  <= 1'b0;
      missQ <= 1'b0;
    end else begin
      hitQ  <= enable & wordEq;
      missQ <= enable & ~wordEq & ~strobe.clrMiss;
    end
  end

  // Output register for the slip request
  always_ff @(posedge clk) begin
    if (rst) syncQ <= 1'b0;
    else     syncQ <= strobe.syncRaw;
  end

  // Consecutive-match run counter
  always_ff @(posedge clk) begin
    if (rst || strobe.clrMatch) matchCnt <= '0;
    else if (strobe.incMatch && !matchDone) matchCnt <= matchCnt + 1'b1;
  end

  // Lock flag
  always_ff @(posedge clk) begin
    if (rst || strobe.clrLock) lockedQ <= 1'b0;
    else if (strobe.setLock)   lockedQ <= 1'b1;
  end

  // Slip counter, modulo SLIP_MOD
  always_ff @(posedge clk) begin
    if (rst) slipCnt <= '0;
    else if (strobe.incSlip)
      slipCnt <= (slipCnt == SLIP_LAST) ? '0 : slipCnt + 1'b1;
  end

  AST_PULSE_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(syncQ) |-> $past(syncQ, 2)); // R2
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(syncQ) |=> syncQ); // R2
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    (syncQ && $past(syncQ)) |=> !syncQ); // R2
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(syncQ) |-> (!$past(syncQ, 2) && !$past(syncQ, 3))); // R3
  AST_SLIP_RANGE: assert property (@(posedge clk) disable iff (rst)
    slipCnt <= SLIP_LAST); // R5
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    (lockedQ && missQ && enable) |=> !lockedQ); // R7

endmodule

// File: rtl/slip_control.sv
module slip_control
  import slip_pkg::*;
#(
  parameter int PULSE_CYCLES = 2,
  parameter int GAP_CYCLES   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        hitQ,
  input  logic        missQ,
  input  logic        matchDone,
  output slipStrobe_t strobe
);

  localparam int PH_MAX = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] PULSE_LAST = PH_W'(PULSE_CYCLES - 1);
  localparam logic [PH_W-1:0] GAP_LAST   = PH_W'(GAP_CYCLES - 1);

  slipState_e state, stateNext;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // Phase counter restarts on every state change
  always_ff @(posedge clk) begin
    if (rst || (stateNext != state)) phase <= '0;
    else                             phase <= phase + 1'b1;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.clrMatch = 1'b1;
        strobe.clrLock  = 1'b1;
        if (enable) stateNext = ST_COMPARE;
      end
      ST_COMPARE: begin
        if (!enable) begin
          strobe.clrMatch = 1'b1;
          stateNext       = ST_IDLE;
        end else if (hitQ) begin
          strobe.incMatch = 1'b1;
          if (matchDone) begin
            strobe.setLock = 1'b1;
            stateNext      = ST_LOCKED;
          end
        end else if (missQ) begin
          strobe.clrMatch = 1'b1;
          strobe.incSlip  = 1'b1;
          stateNext       = ST_PULSE_HI;
        end
      end
      ST_PULSE_HI: begin
        strobe.syncRaw = 1'b1;
        strobe.clrMiss = 1'b1;
        if (phase == PULSE_LAST) stateNext = ST_GAP_LO;
      end
      ST_GAP_LO: begin
        strobe.clrMiss = 1'b1;
        if (phase == GAP_LAST) stateNext = ST_WAIT_REARM;
      end
      ST_WAIT_REARM: begin
        if (!enable)     stateNext = ST_IDLE;
        else if (!missQ) stateNext = ST_COMPARE;
      end
      ST_LOCKED: begin
        if (!enable) begin
          strobe.clrLock  = 1'b1;
          strobe.clrMatch = 1'b1;
          stateNext       = ST_IDLE;
        end else if (missQ) begin
          strobe.clrLock  = 1'b1;
          strobe.clrMatch = 1'b1;
          stateNext       = ST_COMPARE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_REARM_FRESH: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe.syncRaw) |-> $past(missQ)); // R4
  AST_SLIP_THEN_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe.incSlip |=> strobe.syncRaw); // R5
  AST_LOCK_ON_RUN: assert property (@(posedge clk) disable iff (rst)
    strobe.setLock |-> (hitQ && matchDone && enable)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !strobe.incSlip); // R8

endmodule

// File: rtl/slip_align_ctrl.sv
module slip_align_ctrl
  import slip_pkg::*;
#(
  parameter int WORD_W       = 10,
  parameter int LOCK_COUNT   = 4,
  parameter int PULSE_CYCLES = 2,
  parameter int GAP_CYCLES   = 3,
  parameter int SLIP_W       = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] trainPattern,
  output logic              slipReq,
  output logic              locked,
  output logic [SLIP_W-1:0] slipCount
);

  slipStrobe_t strobe;
  logic hitQ, missQ, matchDone;

  slip_control #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES)
  ) i_control (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .hitQ     (hitQ),
    .missQ    (missQ),
    .matchDone(matchDone),
    .strobe   (strobe)
  );

  slip_datapath #(
    .WORD_W    (WORD_W),
    .LOCK_COUNT(LOCK_COUNT),
    .SLIP_MOD  (WORD_W),
    .SLIP_W    (SLIP_W)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .rxWord      (rxWord),
    .trainPattern(trainPattern),
    .strobe      (strobe),
    .hitQ        (hitQ),
    .missQ       (missQ),
    .matchDone   (matchDone),
    .syncQ       (slipReq),
    .lockedQ     (locked),
    .slipCnt     (slipCount)
  );

  AST_SYNC_REG: assert property (@(posedge clk) disable iff (rst)
    $rose(slipReq) |-> ($past(slipCount) != $past(slipCount, 2))); // R1

endmodule

// File: tb/test_slip_align_ctrl.sv
module test_slip_align_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [W-1:0] rxWord = '0;
  logic [W-1:0] trainPattern = '0;
  logic slipReq, locked;
  logic [3:0] slipCount;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slip_align_ctrl i_slip_align_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .rxWord(rxWord),
    .trainPattern(trainPattern), .slipReq(slipReq), .locked(locked),
    .slipCount(slipCount)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] w, input int n);
    logic [W-1:0] r = w;
    for (int i = 0; i < n; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  function automatic logic [W-1:0] rotr(input logic [W-1:0] w, input int n);
    logic [W-1:0] r = w;
    for (int i = 0; i < n; i++) r = {r[0], r[W-1:1]};
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Deserializer model and pulse monitor, all at the falling edge
  int hiRun = 0, loRun = 0, pulseTally = 0;
  bit seenPulse = 0;
  logic prevReq = 0;
  logic [3:0] cnt1 = 0, cnt2 = 0;

  always @(negedge clk) begin
    if (rst) begin
      hiRun = 0; loRun = 0; seenPulse = 0; prevReq = 0; pulseTally = 0;
    end else begin
      if (slipReq && !prevReq) begin
        rxWord = rotl(rxWord, 1);
        pulseTally++;
        chk(cnt1 != cnt2 && slipCount == cnt1, "R1 count step before rise",
            int'(cnt1), int'(cnt2) + 1);
        if (seenPulse) chk(loRun >= 3, "R3 low gap", loRun, 3);
        seenPulse = 1;
        hiRun = 0;
      end
      if (!slipReq && prevReq) begin
        chk(hiRun == 2, "R2 pulse width", hiRun, 2);
        loRun = 0;
      end
      if (slipReq) hiRun++;
      else         loRun++;
      prevReq = slipReq;
    end
    cnt2 = cnt1;
    cnt1 = slipCount;
  end

  // Vector table: {pattern, starting rotation}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {10'h3A1, 4'd0}, {10'h3A1, 4'd3}, {10'h0F3, 4'd7},
    {10'h17C, 4'd9}, {10'h2D5, 4'd1}, {10'h0C7, 4'd5}
  };

  task automatic start_run(input logic [W-1:0] pat, input logic [W-1:0] word, input logic en);
    rst = 1'b1;
    tick(2);
    trainPattern = pat;
    rxWord = word;
    enable = en;
    rst = 1'b0;
  endtask

  task automatic wait_lock(input int limit);
    for (int i = 0; i < limit && !locked; i++) tick(1);
  endtask

  initial begin
    tick(2);
    // R9: reset state
    chk(slipReq == 0, "R9 reset slipReq", slipReq, 0);
    chk(locked == 0, "R9 reset locked", locked, 0);
    chk(slipCount == 0, "R9 reset slipCount", slipCount, 0);

    // Table-driven alignment runs
    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] pat;
      int k;
      pat = VEC[v][13:4];
      k = int'(VEC[v][3:0]);
      start_run(pat, rotr(pat, k), 1'b1);
      wait_lock(300);
      chk(locked == 1, "R10 lock reached", locked, 1);
      chk(pulseTally == k, "R4 requests needed", pulseTally, k);
      chk(int'(slipCount) == k % 10, "R5 slip count", slipCount, k % 10);
      chk(rxWord == pat, "R10 one rotation per request", rxWord, pat);
      tick(20);
      chk(pulseTally == k, "R4 no request after match", pulseTally, k);
    end

    // R6: exact lock timing with aligned word
    start_run(10'h3A1, 10'h3A1, 1'b1);
    tick(4);
    chk(locked == 0, "R6 not yet locked after 4 edges", locked, 0);
    tick(1);
    chk(locked == 1, "R6 locked after 5 edges", locked, 1);

    // R7: mismatch while locked
    rxWord = rotr(10'h3A1, 1);
    tick(1);
    chk(locked == 1, "R7 locked held one edge", locked, 1);
    tick(1);
    chk(locked == 0, "R7 locked cleared", locked, 0);
    wait_lock(200);
    chk(locked == 1 && pulseTally == 1, "R7 relock after one slip", pulseTally, 1);
    chk(slipCount == 1, "R7 slip count", slipCount, 1);

    // R8: drop enable while locked
    enable = 1'b0;
    tick(1);
    chk(locked == 0, "R8 enable low clears lock", locked, 1'b0);

    // R8: disabled with misaligned word
    start_run(10'h3A1, rotr(10'h3A1, 4), 1'b0);
    tick(40);
    chk(pulseTally == 0, "R8 no request while disabled", pulseTally, 0);
    chk(slipCount == 0 && locked == 0, "R8 state idle", slipCount, 0);

    // R5: wrap with a never-matching word
    start_run(10'h3A1, 10'h000, 1'b1);
    for (int i = 0; i < 400 && pulseTally < 12; i++) tick(1);
    chk(slipCount == 2, "R5 wrap after 12 requests", slipCount, 2);
    chk(slipReq == 1, "R2 pulse in progress", slipReq, 1);

    // R9: reset mid-pulse
    rst = 1'b1;
    tick(1);
    chk(slipReq == 0, "R9 mid-pulse reset slipReq", slipReq, 0);
    chk(slipCount == 0 && locked == 0, "R9 mid-pulse reset state", slipCount, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule